// File: doc/BRIEF.md
# Video Link Pseudo-Random Self-Test

This block lets a serial video link test itself with no external pattern source and no logger. After a start pulse, the transmit-side generator replaces the pixel payload with a PRBS-15 sequence (x^15 + x^14 + 1). It emits 24 bits per payload word and advances only when the serializer accepts a word. The receive-side checker takes its LFSR state from the first word it receives. It then predicts every later word on its own and compares each one against the word that arrives.

A programmable count of compared words sets how long the test runs. While the test runs, the `pass` output flips once for every word that arrives wrong. When the count is used up, `done` rises and `pass` settles to the verdict: 1 if no compared word was wrong, 0 otherwise. An error counter holds the number of wrong words and can be read once the test has finished. A new start pulse abandons any test in progress, clears all results and re-aligns the checker.

Top module: `vlink_bist_top`

## Requirements
- R1: The pattern is PRBS-15 (next bit = state[14] XOR state[13], shifted in at the LSB), loaded with SEED on start. Each 24-bit word holds the next 24 generated bits, with the earliest bit in bit 23. The word advances only on a cycle where `tx_valid` and `tx_ready` are both high, and holds otherwise.
- R2: The first word accepted on `rx_valid` after start only seeds the checker: its state becomes `rx_word[14:0]`. No error is counted for that word, even if it was corrupted.
- R3: Every later word with `rx_valid` high is compared with the checker's own prediction. Each mismatch adds one to `err_cnt`.
- R4: `pass` goes to 1 on the cycle after start. It inverts once for each mismatched word, except the final compared word.
- R5: `dur_words` is sampled at start and counts compared words. `done` rises on the cycle after the last one is accepted. A duration of 0 raises `done` on the cycle after start, with `pass` = 1.
- R6: When `done` rises, `pass` = 1 if no compared word mismatched and 0 if any did.
- R7: `err_cnt` (ERR_W bits) saturates at its all-ones value.
- R8: A start pulse at any time clears `err_cnt`, restarts the duration, reloads the generator and re-seeds the checker.
- R9: After `done`, words on `rx_valid` leave `pass`, `err_cnt` and `done` unchanged until the next start.
- R10: Reset leaves `pass`, `done`, `err_cnt` and `tx_valid` at 0.
- R11: `tx_valid` is high from the cycle after start until `done` rises, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle pulse that begins a test |
| dur_words | input | DUR_W | Number of words to compare |
| tx_ready | input | 1 | Serializer accepts the current test word |
| tx_valid | output | 1 | A test word is being offered |
| tx_word | output | WORD_W | Test payload word |
| rx_valid | input | 1 | A received payload word is present |
| rx_word | input | WORD_W | Received payload word |
| pass | output | 1 | Toggles on errors while running; holds the verdict when done |
| done | output | 1 | Test duration has expired |
| err_cnt | output | ERR_W | Number of wrong words, saturating |

## Verification
The bench builds the block with ERR_W = 4, so saturation is reached after only 15 errored words within a 40-word run. The other parameters keep their defaults: a 24-bit word, PRBS-15 taps, an all-ones seed and a 32-bit duration. Those defaults make the bench's own bit-by-bit model of the first words directly comparable with the port values. The transmit port is looped back to the receive port through a corruption mask and a throttled `tx_ready`. This reaches single errors, errors on every word, a corrupted seed word, a zero duration and back-to-back restarts.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SEED = 2'd1,
      PH_RUN  = 2'd2,
      PH_DONE = 2'd3
   } lbt_phase_e;
endpackage

// File: rtl/lbt_lfsr_word.sv
// Produces the next WORD_W bits of a Fibonacci LFSR, earliest bit in the MSB.
module lbt_lfsr_word #(
   parameter int WORD_W = 24,
   parameter int TAP_HI = 15,
   parameter int TAP_LO = 14
) (
   input  logic [TAP_HI-1:0] state,
   output logic [WORD_W-1:0] word
);
   localparam int LFSR_W = TAP_HI;

   logic [LFSR_W-1:0] walk;
   logic              fb;

   always_comb begin
      walk = state;
      fb   = 1'b0;
      word = '0;
      for (int i = 0; i < WORD_W; i++) begin
         fb                 = walk[TAP_HI-1] ^ walk[TAP_LO-1];
         word[WORD_W-1-i]   = fb;
         walk               = {walk[LFSR_W-2:0], fb};
      end
   end
endmodule

// File: rtl/lbt_gen.sv
module lbt_gen #(
   parameter int                WORD_W = 24,
   parameter int                TAP_HI = 15,
   parameter int                TAP_LO = 14,
   parameter logic [TAP_HI-1:0] SEED   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [WORD_W-1:0] tx_word
);
   localparam int LFSR_W = TAP_HI;

   logic [LFSR_W-1:0] gen_state;

   lbt_lfsr_word #(.WORD_W(WORD_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_word (
      .state (gen_state),
      .word  (tx_word)
   );

   assign tx_valid = active;

   always_ff @(posedge clk) begin
      if (!rst_n)                  gen_state <= SEED;
      else if (start)              gen_state <= SEED;
      else if (active && tx_ready) gen_state <= tx_word[LFSR_W-1:0];
   end

   a_r1_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !start) |=> $stable(tx_word));
endmodule

// File: rtl/lbt_chk.sv
module lbt_chk #(
   parameter int WORD_W = 24,
   parameter int TAP_HI = 15,
   parameter int TAP_LO = 14
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  lbt_pkg::lbt_phase_e     phase,
   input  logic                    rx_valid,
   input  logic [WORD_W-1:0]       rx_word,
   output logic                    word_cmp,
   output logic                    word_err
);
   import lbt_pkg::*;
   localparam int LFSR_W = TAP_HI;

   logic [LFSR_W-1:0] chk_state;
   logic [WORD_W-1:0] exp_word;

   lbt_lfsr_word #(.WORD_W(WORD_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_word (
      .state (chk_state),
      .word  (exp_word)
   );

   assign word_cmp = rx_valid && (phase == PH_RUN);
   assign word_err = word_cmp && (rx_word != exp_word);

   always_ff @(posedge clk) begin
      if (!rst_n)
         chk_state <= '0;
      else if (rx_valid && phase == PH_SEED)
         chk_state <= rx_word[LFSR_W-1:0];
      else if (word_cmp)
         chk_state <= exp_word[LFSR_W-1:0];
   end
endmodule

// File: rtl/lbt_ctl.sv
module lbt_ctl #(
   parameter int DUR_W   = 32,
   parameter int ERR_W   = 16,
   parameter bit SAT_ERR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [DUR_W-1:0]    dur_words,
   input  logic                rx_valid,
   input  logic                word_cmp,
   input  logic                word_err,
   output lbt_pkg::lbt_phase_e phase,
   output logic                pass,
   output logic                done,
   output logic [ERR_W-1:0]    err_cnt
);
   import lbt_pkg::*;
   localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

   logic [DUR_W-1:0] remain;
   logic             err_any;
   logic             last;
   logic [ERR_W-1:0] err_inc;

   assign last = (remain == DUR_W'(1));
   assign done = (phase == PH_DONE);

   generate
      if (SAT_ERR) begin : g_sat
         assign err_inc = (err_cnt == ERR_MAX) ? err_cnt : err_cnt + 1'b1;
         a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (err_cnt == ERR_MAX && !start) |=> (err_cnt == ERR_MAX));
      end else begin : g_wrap
         assign err_inc = err_cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         remain  <= '0;
         err_cnt <= '0;
         err_any <= 1'b0;
         pass    <= 1'b0;
      end else if (start) begin
         remain  <= dur_words;
         err_cnt <= '0;
         err_any <= 1'b0;
         pass    <= 1'b1;
         phase   <= (dur_words == '0) ? PH_DONE : PH_SEED;
      end else begin
         case (phase)
            PH_SEED: if (rx_valid) phase <= PH_RUN;
            PH_RUN: if (word_cmp) begin
               remain <= remain - 1'b1;
               if (word_err) begin
                  err_cnt <= err_inc;
                  err_any <= 1'b1;
               end
               if (last) begin
                  phase <= PH_DONE;
                  pass  <= !(err_any || word_err);
               end else if (word_err) begin
                  pass <= ~pass;
               end
            end
            default: ;
         endcase
      end
   end

   a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN && word_err && !last && !start) |=> (pass != $past(pass)));
   a_r6_fail_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err_cnt != '0) |-> !pass);
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (err_cnt == '0 && pass));
   a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(err_cnt) && $stable(pass)));
endmodule

// File: rtl/vlink_bist_top.sv
module vlink_bist_top #(
   parameter int                WORD_W  = 24,
   parameter int                TAP_HI  = 15,
   parameter int                TAP_LO  = 14,
   parameter logic [TAP_HI-1:0] SEED    = '1,
   parameter int                DUR_W   = 32,
   parameter int                ERR_W   = 16,
   parameter bit                SAT_ERR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DUR_W-1:0]  dur_words,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [WORD_W-1:0] tx_word,
   input  logic              rx_valid,
   input  logic [WORD_W-1:0] rx_word,
   output logic              pass,
   output logic              done,
   output logic [ERR_W-1:0]  err_cnt
);
   import lbt_pkg::*;

   initial begin
      assert (TAP_LO > 0 && TAP_LO < TAP_HI) else $fatal(1, "tap order");
      assert (WORD_W >= TAP_HI) else $fatal(1, "word narrower than LFSR");
      assert (SEED != '0) else $fatal(1, "zero seed locks the LFSR");
      assert (ERR_W >= 1 && DUR_W >= 1) else $fatal(1, "counter width");
   end

   lbt_phase_e phase;
   logic       word_cmp;
   logic       word_err;
   logic       active;

   assign active = (phase == PH_SEED) || (phase == PH_RUN);

   lbt_gen #(.WORD_W(WORD_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .active   (active),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_word  (tx_word)
   );

   lbt_chk #(.WORD_W(WORD_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)) u_chk (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .rx_valid (rx_valid),
      .rx_word  (rx_word),
      .word_cmp (word_cmp),
      .word_err (word_err)
   );

   lbt_ctl #(.DUR_W(DUR_W), .ERR_W(ERR_W), .SAT_ERR(SAT_ERR)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .dur_words (dur_words),
      .rx_valid  (rx_valid),
      .word_cmp  (word_cmp),
      .word_err  (word_err),
      .phase     (phase),
      .pass      (pass),
      .done      (done),
      .err_cnt   (err_cnt)
   );

   a_r11_valid_vs_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tx_valid);
endmodule

// File: tb/vlink_bist_top_test.sv
module vlink_bist_top_test;
   localparam int ERRW = 4;
   localparam int SATV = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dur_words = '0;
   logic        tx_ready = 1'b1;
   logic        tx_valid;
   logic [23:0] tx_word;
   logic        rx_valid;
   logic [23:0] rx_word;
   logic        pass, done;
   logic [ERRW-1:0] err_cnt;
   logic [23:0] mask = '0;
   logic        ovr = 1'b0, ovr_valid = 1'b0;
   logic [23:0] ovr_word = '0;

   int total = 0, bad = 0, cycles = 0;
   int idx_o, tog_o;

   always #4 clk = ~clk;

   assign rx_word  = ovr ? ovr_word  : (tx_word ^ mask);
   assign rx_valid = ovr ? ovr_valid : (tx_valid && tx_ready);

   vlink_bist_top #(.ERR_W(ERRW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dur_words(dur_words),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_word(tx_word),
      .rx_valid(rx_valid), .rx_word(rx_word), .pass(pass), .done(done),
      .err_cnt(err_cnt)
   );

   // independent PRBS-15 word model, earliest bit in bit 23
   function automatic logic [23:0] mdl_word(input logic [14:0] st);
      logic [14:0] s = st;
      logic [23:0] w = '0;
      for (int i = 0; i < 24; i++) begin
         logic b = s[14] ^ s[13];
         w[23-i] = b;
         s = {s[13:0], b};
      end
      return w;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         summary();
      end
   end

   // Start a test and loop back until done; mask corrupts chosen words.
   task automatic run(input int dur, input int every, input int gap, input bit seed_bad);
      int idx = 0, cyc = 0, tog = 0;
      logic prev;
      bit acc;
      @(negedge clk); start = 1'b1; dur_words = dur; mask = '0; tx_ready = 1'b1;
      @(negedge clk); start = 1'b0;
      prev = pass;
      while (!done && cyc < 5000) begin
         tx_ready = (gap == 0) || ((cyc % gap) != gap - 1);
         if (idx == 0) mask = seed_bad ? 24'h000001 : '0;
         else mask = (every != 0 && (idx % every) == 0) ? (24'h1 << (idx % 24)) : '0;
         acc = tx_valid && tx_ready;
         @(negedge clk);
         if (acc) idx++;
         if (pass != prev && !done) tog++;
         prev = pass;
         cyc++;
      end
      mask = '0;
      if (cyc >= 5000) check("R5 run timeout", cyc, 0);
      idx_o = idx;
      tog_o = tog;
   endtask

   // dur, every (0 = none), gap (0 = always ready), seed_bad
   localparam logic [31:0] VEC [9] = '{
      {8'd10, 8'd0, 8'd0, 8'd0},
      {8'd10, 8'd3, 8'd0, 8'd0},
      {8'd12, 8'd4, 8'd3, 8'd0},
      {8'd8,  8'd1, 8'd0, 8'd0},
      {8'd40, 8'd1, 8'd2, 8'd0},
      {8'd6,  8'd0, 8'd0, 8'd1},
      {8'd1,  8'd1, 8'd0, 8'd0},
      {8'd0,  8'd0, 8'd0, 8'd0},
      {8'd25, 8'd0, 8'd4, 8'd0}
   };

   initial begin
      logic [23:0] w0, w1;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 pass", pass, 0);
      check("R10 done", done, 0);
      check("R10 err_cnt", err_cnt, 0);
      check("R10 tx_valid", tx_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", {done, tx_valid}, 0);

      // R1 first words and hold while not ready
      start = 1'b1; dur_words = 50;
      @(negedge clk); start = 1'b0; tx_ready = 1'b0;
      w0 = mdl_word(15'h7FFF);
      w1 = mdl_word(w0[14:0]);
      check("R11 tx_valid after start", tx_valid, 1);
      check("R4 pass after start", pass, 1);
      check("R1 first word", tx_word, w0);
      @(negedge clk);
      check("R1 hold while not ready", tx_word, w0);
      tx_ready = 1'b1;
      @(negedge clk);
      check("R1 second word", tx_word, w1);

      // R8 errors on a running test, then restart cleanly
      mask = 24'hFFFFFF;
      repeat (6) @(negedge clk);
      mask = '0;
      check("R3 errors counted before restart", (err_cnt != 0), 1);
      run(10, 0, 0, 0);
      check("R8 err cleared by restart", err_cnt, 0);
      check("R8 pass after restart", pass, 1);

      for (int v = 0; v < 9; v++) begin
         int dur, ev, gp, sb, raw, ex_err, ex_tog;
         dur = VEC[v][31:24]; ev = VEC[v][23:16]; gp = VEC[v][15:8]; sb = VEC[v][7:0];
         raw = sb ? dur : ((ev == 0) ? 0 : dur / ev);
         ex_err = (raw > SATV) ? SATV : raw;
         if (dur == 0) ex_tog = 0;
         else ex_tog = sb ? dur - 1 : ((ev == 0) ? 0 : (dur - 1) / ev);
         run(dur, ev, gp, sb[0]);
         check($sformatf("R3/R7/R2 err_cnt vec%0d", v), err_cnt, ex_err);
         check($sformatf("R6 verdict vec%0d", v), pass, (raw == 0));
         check($sformatf("R5 done vec%0d", v), done, 1);
         check($sformatf("R5 words used vec%0d", v), idx_o, (dur == 0) ? 0 : dur + 1);
         check($sformatf("R4 toggles vec%0d", v), tog_o, ex_tog);
         check($sformatf("R11 tx_valid low vec%0d", v), tx_valid, 0);
      end

      // R9 words after done are ignored
      run(5, 0, 0, 0);
      ovr = 1'b1; ovr_valid = 1'b1;
      for (int k = 0; k < 6; k++) begin
         ovr_word = 24'h5A5A00 ^ k;
         @(negedge clk);
      end
      ovr = 1'b0; ovr_valid = 1'b0;
      check("R9 err_cnt unchanged", err_cnt, 0);
      check("R9 pass unchanged", pass, 1);
      check("R9 done held", done, 1);

      summary();
   end
endmodule